// File: doc/BRIEF.md
# Interrupt Event and Graceful Stop Controller

This block collects the interrupt causes of a network DMA channel pair into one 32-bit event register and drives three level-sensitive interrupt lines from it: transmit, receive and error. Hardware sources pulse event inputs to set event bits. Software writes 1s to the event register to acknowledge causes. A mask register selects which newly arriving causes may raise a line. A line is lowered only by a software acknowledge that leaves its group of causes empty.

The same write port reaches a small DMA control register that carries two stop requests, one per direction. A stop request made while its path has no buffer in flight completes at once. A stop request made while the path is busy completes when the busy flag drops. In both cases completion sets a stop-done cause, which belongs to the error group.

Register selection is `wr_addr_i`: 0 = event register (write-1-to-clear), 1 = mask register, 2 = DMA control, 3 = unused. Event bit positions are: bit 0 transmit frame (transmit group); bit 1 receive frame (receive group); bits 2 to 21 the error group, where bit 2 is receive-stop-done and bit 3 is transmit-stop-done; bits 22 to 31 belong to no group. In DMA control, bit 0 requests a receive stop and bit 1 requests a transmit stop. The mask bit with the same position as an event bit enables that event.

Top module: `irq_evt_ctrl`

## Requirements
- R1: After reset, all event bits, mask bits and stop requests are 0 and all three lines are low. Reset asserts asynchronously, and its release takes effect two clock edges later.
- R2: A pulse on `evt_pulse_i[n]` sets event bit n at the next clock edge. If mask bit n is 1 and bit n lies in a group, that group's line is high from the same edge. If mask bit n is 0, no line is raised.
- R3: A write to address 0 clears each event bit written as 1 and leaves each bit written as 0 unchanged.
- R4: After a write to address 0, the transmit line goes low if event bit 0 is clear. Otherwise it stays high.
- R5: After a write to address 0, the receive line goes low if event bit 1 is clear. Otherwise it stays high.
- R6: After a write to address 0, the error line goes low only if all of event bits 2 to 21 are clear.
- R7: When a pulse sets an event bit in the same cycle as a write that clears it, the bit ends up set.
- R8: A write to address 2 with bit 0 set while `rx_busy_i` is low sets event bit 2 at the next edge. If mask bit 2 is 1, the error line also goes high. With mask bit 2 at 0, the event is still recorded.
- R9: A write to address 2 with bit 1 set while `tx_busy_i` is low sets event bit 3 at the next edge. If mask bit 3 is 1, the error line also goes high.
- R10: A stop requested while its busy flag is high does not complete at the write. It completes when the busy flag falls while the request bit is still 1. A busy flag falling with no request set sets nothing.
- R11: Writes to the mask register never change a line. Pulses on bits 22 to 31 raise no line. Writes to address 3 are ignored.
- R12: A line is lowered by nothing but a write to address 0. A mask write does not lower it, and neither does the passing of time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | 32 | Write data |
| evt_pulse_i | input | 32 | One-cycle event set pulses, one per event bit |
| rx_busy_i | input | 1 | Receive buffer in flight |
| tx_busy_i | input | 1 | Transmit buffer in flight |
| tx_irq_o | output | 1 | Transmit interrupt line |
| rx_irq_o | output | 1 | Receive interrupt line |
| err_irq_o | output | 1 | Error interrupt line |

## Verification
The hardest state to reach from the ports is a recorded cause that never showed on a line. Examples are a stop completion while its mask bit is off, or a bit that survived a same-cycle clear. The event register has no read path, so the stimulus arranges for a second, enabled cause to raise the error or transmit line. It then acknowledges only that second cause. The line stays high only if the hidden bit is still set. Deferred stop completion is reached by holding a busy flag high across the control write and dropping it a few cycles later.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;
  localparam int unsigned EVT_W     = 32;
  localparam int unsigned ADDR_W    = 2;
  localparam int unsigned NUM_LINES = 3;
  localparam int unsigned NUM_PATHS = 2;

  localparam int unsigned LINE_TX  = 0;
  localparam int unsigned LINE_RX  = 1;
  localparam int unsigned LINE_ERR = 2;

  localparam int unsigned EV_TXF       = 0;
  localparam int unsigned EV_RXF       = 1;
  localparam int unsigned EV_RX_STOPPED = 2;
  localparam int unsigned EV_TX_STOPPED = 3;
  localparam int unsigned ERR_LO       = 2;
  localparam int unsigned ERR_HI       = 21;

  localparam logic [ADDR_W-1:0] REG_EVT  = 2'd0;
  localparam logic [ADDR_W-1:0] REG_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] REG_DMA  = 2'd2;

  localparam int unsigned PATH_RX = 0;
  localparam int unsigned PATH_TX = 1;

  function automatic logic [EVT_W-1:0] group_mask(input int unsigned idx);
    logic [EVT_W-1:0] m;
    m = '0;
    case (idx)
      LINE_TX: m[EV_TXF] = 1'b1;
      LINE_RX: m[EV_RXF] = 1'b1;
      default: begin
        for (int b = ERR_LO; b <= ERR_HI; b++) m[b] = 1'b1;
      end
    endcase
    return m;
  endfunction
endpackage

// File: rtl/evt_reg_bank.sv
module evt_reg_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] evt_o,
  output logic [W-1:0] evt_nxt_o
);
  logic [W-1:0] evt_q, evt_d;
  logic [W-1:0] clr_eff;

  always_comb begin
    clr_eff = clr_en_i ? clr_i : '0;
    evt_d   = (evt_q & ~clr_eff) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= evt_d;
  end

  assign evt_o     = evt_q;
  assign evt_nxt_o = evt_d;

  // R2 R7
  evt_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((evt_q & $past(set_i)) == $past(set_i)));

  // R3
  evt_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && |(clr_i & ~set_i)) |=> ((evt_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/gstop_ctrl.sv
module gstop_ctrl #(
  parameter int unsigned NPATH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_wr_i,
  input  logic [NPATH-1:0] ctl_bits_i,
  input  logic [NPATH-1:0] busy_i,
  output logic [NPATH-1:0] done_o
);
  for (genvar p = 0; p < NPATH; p++) begin : g_path
    logic stop_q, stop_d, stop_en;
    logic busy_q;
    logic done_now, done_late;

    always_comb begin
      stop_en   = ctl_wr_i;
      stop_d    = ctl_bits_i[p];
      done_now  = ctl_wr_i && ctl_bits_i[p] && !busy_i[p];
      done_late = busy_q && !busy_i[p] && stop_q;
      done_o[p] = done_now || done_late;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stop_q <= 1'b0;
        busy_q <= 1'b0;
      end else begin
        if (stop_en) stop_q <= stop_d;
        busy_q <= busy_i[p];
      end
    end

    // R10
    gstop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o[p] |-> !busy_i[p]);
  end
endmodule

// File: rtl/irq_line.sv
module irq_line #(
  parameter int unsigned   W     = 32,
  parameter logic [W-1:0]  GROUP = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] evt_nxt_i,
  input  logic         evt_wr_i,
  output logic         line_o
);
  logic line_q, line_d;
  logic raise, lower;

  always_comb begin
    raise = |(set_i & mask_i & GROUP);
    lower = evt_wr_i && ((evt_nxt_i & GROUP) == '0);
    if (raise)      line_d = 1'b1;
    else if (lower) line_d = 1'b0;
    else            line_d = line_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= 1'b0;
    else         line_q <= line_d;
  end

  assign line_o = line_q;

  // R2
  line_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_q) |-> $past(|(set_i & mask_i & GROUP)));

  // R12
  line_fall_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(line_q) |-> $past(evt_wr_i));

  // R6
  line_fall_group_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(line_q) |-> ((evt_i & GROUP) == '0));
endmodule

// File: rtl/irq_evt_ctrl.sv
module irq_evt_ctrl
  import irq_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [EVT_W-1:0]  wr_data_i,
  input  logic [EVT_W-1:0]  evt_pulse_i,
  input  logic              rx_busy_i,
  input  logic              tx_busy_i,
  output logic              tx_irq_o,
  output logic              rx_irq_o,
  output logic              err_irq_o
);
  logic rst_meta_q, rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  logic evt_wr, mask_wr, dma_wr;
  logic [EVT_W-1:0] mask_q, mask_d;
  logic [EVT_W-1:0] set_vec, evt_q, evt_nxt;
  logic [NUM_PATHS-1:0] stop_req, busy_vec, stop_done;
  logic [NUM_LINES-1:0] line_vec;

  always_comb begin
    evt_wr  = wr_en_i && (wr_addr_i == REG_EVT);
    mask_wr = wr_en_i && (wr_addr_i == REG_MASK);
    dma_wr  = wr_en_i && (wr_addr_i == REG_DMA);
    mask_d  = wr_data_i;
    stop_req[PATH_RX] = wr_data_i[PATH_RX];
    stop_req[PATH_TX] = wr_data_i[PATH_TX];
    busy_vec[PATH_RX] = rx_busy_i;
    busy_vec[PATH_TX] = tx_busy_i;
    set_vec = evt_pulse_i;
    set_vec[EV_RX_STOPPED] = evt_pulse_i[EV_RX_STOPPED] | stop_done[PATH_RX];
    set_vec[EV_TX_STOPPED] = evt_pulse_i[EV_TX_STOPPED] | stop_done[PATH_TX];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= mask_d;
  end

  evt_reg_bank #(.W(EVT_W)) bank_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .clr_en_i  (evt_wr),
    .clr_i     (wr_data_i),
    .set_i     (set_vec),
    .evt_o     (evt_q),
    .evt_nxt_o (evt_nxt)
  );

  gstop_ctrl #(.NPATH(NUM_PATHS)) gstop_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .ctl_wr_i   (dma_wr),
    .ctl_bits_i (stop_req),
    .busy_i     (busy_vec),
    .done_o     (stop_done)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    irq_line #(.W(EVT_W), .GROUP(group_mask(g))) line_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_n),
      .set_i     (set_vec),
      .mask_i    (mask_q),
      .evt_i     (evt_q),
      .evt_nxt_i (evt_nxt),
      .evt_wr_i  (evt_wr),
      .line_o    (line_vec[g])
    );
  end

  assign tx_irq_o  = line_vec[LINE_TX];
  assign rx_irq_o  = line_vec[LINE_RX];
  assign err_irq_o = line_vec[LINE_ERR];

  // R11
  mask_wr_no_line_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mask_wr && !evt_wr && (evt_pulse_i == '0) && (stop_done == '0)) |=> $stable(line_vec));
endmodule

// File: tb/irq_evt_ctrl_tb_top.sv
module irq_evt_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        wr_en_i;
  logic [1:0]  wr_addr_i;
  logic [31:0] wr_data_i;
  logic [31:0] evt_pulse_i;
  logic        rx_busy_i, tx_busy_i;
  logic        tx_irq_o, rx_irq_o, err_irq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_evt_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .evt_pulse_i(evt_pulse_i), .rx_busy_i(rx_busy_i),
    .tx_busy_i(tx_busy_i), .tx_irq_o(tx_irq_o), .rx_irq_o(rx_irq_o),
    .err_irq_o(err_irq_o)
  );

  // {req, wr, addr, data, pulse, rx_busy, tx_busy, expected {tx,rx,err}}
  localparam int NV = 36;
  localparam logic [75:0] VECS [0:NV-1] = '{
    {4'd11, 1'b1, 2'd1, 32'h003FFFFF, 32'h0, 1'b0, 1'b0, 3'b000}, // R11 mask write
    {4'd2,  1'b0, 2'd0, 32'h0, 32'h00000001, 1'b0, 1'b0, 3'b100}, // R2 tx raise
    {4'd2,  1'b0, 2'd0, 32'h0, 32'h00000002, 1'b0, 1'b0, 3'b110}, // R2 rx raise
    {4'd5,  1'b1, 2'd0, 32'h00000002, 32'h0, 1'b0, 1'b0, 3'b100}, // R5 R3 clear rx only
    {4'd4,  1'b1, 2'd0, 32'h00000001, 32'h0, 1'b0, 1'b0, 3'b000}, // R4
    {4'd2,  1'b0, 2'd0, 32'h0, 32'h00000220, 1'b0, 1'b0, 3'b001}, // R2 err raise
    {4'd6,  1'b1, 2'd0, 32'h00000020, 32'h0, 1'b0, 1'b0, 3'b001}, // R6 one left
    {4'd6,  1'b1, 2'd0, 32'h00000200, 32'h0, 1'b0, 1'b0, 3'b000}, // R6 empty
    {4'd11, 1'b0, 2'd0, 32'h0, 32'h02000001, 1'b0, 1'b0, 3'b100}, // R11 ungrouped bit
    {4'd11, 1'b1, 2'd3, 32'hFFFFFFFF, 32'h0, 1'b0, 1'b0, 3'b100}, // R11 addr 3 ignored
    {4'd12, 1'b1, 2'd1, 32'h0, 32'h0, 1'b0, 1'b0, 3'b100},        // R12 mask write keeps line
    {4'd4,  1'b1, 2'd0, 32'h0, 32'h0, 1'b0, 1'b0, 3'b100},        // R4 bit still set
    {4'd4,  1'b1, 2'd0, 32'h00000001, 32'h0, 1'b0, 1'b0, 3'b000}, // R4
    {4'd2,  1'b0, 2'd0, 32'h0, 32'h00000001, 1'b0, 1'b0, 3'b000}, // R2 masked off
    {4'd11, 1'b1, 2'd1, 32'h003FFFFF, 32'h0, 1'b0, 1'b0, 3'b000}, // R11 mask no raise
    {4'd3,  1'b1, 2'd0, 32'h00000001, 32'h0, 1'b0, 1'b0, 3'b000}, // R3
    {4'd2,  1'b0, 2'd0, 32'h0, 32'h00000001, 1'b0, 1'b0, 3'b100}, // R2
    {4'd7,  1'b1, 2'd0, 32'h00000001, 32'h00000001, 1'b0, 1'b0, 3'b100}, // R7 collide
    {4'd7,  1'b1, 2'd0, 32'h0, 32'h0, 1'b0, 1'b0, 3'b100},        // R7 bit held
    {4'd3,  1'b1, 2'd0, 32'h00000001, 32'h0, 1'b0, 1'b0, 3'b000}, // R3
    {4'd8,  1'b1, 2'd2, 32'h00000001, 32'h0, 1'b0, 1'b0, 3'b001}, // R8 rx stop idle
    {4'd8,  1'b1, 2'd0, 32'h00000004, 32'h0, 1'b0, 1'b0, 3'b000}, // R8 bit 2
    {4'd10, 1'b1, 2'd2, 32'h00000002, 32'h0, 1'b0, 1'b1, 3'b000}, // R10 busy at write
    {4'd10, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 1'b1, 3'b000},        // R10 still busy
    {4'd10, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 1'b0, 3'b001},        // R10 fall completes
    {4'd9,  1'b1, 2'd0, 32'h00000008, 32'h0, 1'b0, 1'b0, 3'b000}, // R9 bit 3
    {4'd9,  1'b1, 2'd2, 32'h00000002, 32'h0, 1'b0, 1'b0, 3'b001}, // R9 tx stop idle
    {4'd9,  1'b1, 2'd0, 32'h00000008, 32'h0, 1'b0, 1'b0, 3'b000}, // R9
    {4'd10, 1'b0, 2'd0, 32'h0, 32'h0, 1'b1, 1'b0, 3'b000},        // R10 rx busy
    {4'd10, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 1'b0, 3'b000},        // R10 fall no request
    {4'd11, 1'b1, 2'd1, 32'h003FFFF3, 32'h0, 1'b0, 1'b0, 3'b000}, // R11
    {4'd8,  1'b1, 2'd2, 32'h00000003, 32'h0, 1'b0, 1'b0, 3'b000}, // R8 masked completion
    {4'd11, 1'b1, 2'd1, 32'h003FFFFF, 32'h0, 1'b0, 1'b0, 3'b000}, // R11
    {4'd2,  1'b0, 2'd0, 32'h0, 32'h00000020, 1'b0, 1'b0, 3'b001}, // R2
    {4'd8,  1'b1, 2'd0, 32'h00000020, 32'h0, 1'b0, 1'b0, 3'b001}, // R8 hidden bits 2,3 held
    {4'd8,  1'b1, 2'd0, 32'h0000000C, 32'h0, 1'b0, 1'b0, 3'b000}  // R8
  };

  task automatic check_lines(input logic [2:0] exp, input int req, input string what);
    logic [2:0] act;
    act = {tx_irq_o, rx_irq_o, err_irq_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: lines tx/rx/err actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic wr, input logic [1:0] addr, input logic [31:0] data,
                       input logic [31:0] pulse, input logic rxb, input logic txb);
    wr_en_i = wr; wr_addr_i = addr; wr_data_i = data;
    evt_pulse_i = pulse; rx_busy_i = rxb; tx_busy_i = txb;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0; evt_pulse_i = '0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    evt_pulse_i = '0; rx_busy_i = 1'b0; tx_busy_i = 1'b0;
    do_reset();
    check_lines(3'b000, 1, "lines after reset");      // R1
    apply(1'b0, 2'd0, 32'h0, 32'h00000003, 1'b0, 1'b0);
    check_lines(3'b000, 1, "mask zero after reset");  // R1

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i][71], VECS[i][70:69], VECS[i][68:37], VECS[i][36:5], VECS[i][4], VECS[i][3]);
      check_lines(VECS[i][2:0], int'(VECS[i][75:72]), $sformatf("vector %0d", i));
    end

    // R12: idle cycles leave a raised line high
    apply(1'b0, 2'd0, 32'h0, 32'h00000001, 1'b0, 1'b0);
    repeat (5) @(negedge clk_i);
    check_lines(3'b100, 12, "line held while idle");

    // R1: asynchronous reset drops lines at once
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check_lines(3'b000, 1, "async reset");
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check_lines(3'b000, 1, "after second reset");

    // R1: stop requests cleared by reset, so busy fall completes nothing
    apply(1'b1, 2'd1, 32'h003FFFFF, 32'h0, 1'b0, 1'b0);
    apply(1'b0, 2'd0, 32'h0, 32'h0, 1'b1, 1'b1);
    apply(1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 1'b0);
    check_lines(3'b000, 1, "no stop after reset");

    // R10: rx stop deferred then completed on fall
    apply(1'b1, 2'd2, 32'h00000001, 32'h0, 1'b1, 1'b0);
    check_lines(3'b000, 10, "rx stop pending");
    apply(1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 1'b0);
    check_lines(3'b001, 10, "rx stop completes on fall");

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule